// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 16-bit down-counter driven from the system clock through a two-ratio prescaler. Software programs it through a byte-wide register port. It writes a reload value as two bytes, then writes a control byte that can start or stop counting, request a reload and pick the prescale ratio. Reads of the two count addresses return the live counter value. Reads of the control address return the current control state.

The timer counts down once per prescaler tick while running. When the count steps from one to zero, a timeout flag rises. The flag is also driven straight onto an output pin. The counter then rests at zero until software reloads it. Software clears the flag by writing one to its bit or by stopping the timer.

Register map, 2-bit address: 0 is control, 1 is count bits 7..0, 2 is count bits 15..8, and 3 reads as zero. The control byte holds run in bit 0, load in bit 1, clock select in bit 2 and the timeout flag in bit 3. Bits 7..4 read as zero.

Top module: `cdtimer_top`

## Requirements
- R1: After a synchronous active-low reset, the control byte, both count bytes and the timeout output all read zero.
- R2: With run (control bit 0) at 1, the count drops by one on each prescaler tick. With run at 0, the count holds its value whatever time passes.
- R3: Writing 1 to load (control bit 1) sets that bit, which reads back as 1 in the cycle after the write. On the next clock edge the reload value is copied into the counter and the bit returns to 0 by itself.
- R4: With clock select (control bit 2) at 0, a tick occurs every 16 system clocks. With clock select at 1, a tick occurs every 2 system clocks.
- R5: When a tick takes the count from 1 to 0, the timeout flag (control bit 3 and the `timeout` port) becomes 1 on that same edge.
- R6: A count of zero stays at zero on further ticks and never wraps to the maximum value. The timeout flag stays set.
- R7: A control write with bit 3 at 1 clears the timeout flag. A control write with bit 3 at 0 and run at 1 leaves the flag as it was.
- R8: A control write with run at 0 clears the timeout flag.
- R9: A control write that keeps run at 1 while the timer already runs leaves the clock select bit unchanged. Clock select is taken only when the timer is stopped or stopping.
- R10: Writes to address 1 and 2 set the low and high reload bytes. Reads of address 1 and 2 return count bits 7..0 and 15..8.
- R11: A write that starts the timer from stopped restarts the prescaler, so the first decrement falls a full prescale period after the write edge. When load and start share one write, the reload completes before that first decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register address (0 control, 1 count low, 2 count high) |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr`, combinational |
| timeout | output | 1 | Timeout flag |

## Verification
On every cycle, the assertions check the following:
- A zero count stays put.
- A stopped counter holds its value.
- A running counter never moves by more than one step.
- A pending load copies the reload value and then clears itself.
- Clock select cannot change under a running write.
- A stop write clears the flag.
- The flag only rises at zero.

Only the bench scenarios show the exact tick spacing for each ratio, the prescaler restart on start, and the counts reached after long random runs. The bench also shows the byte mapping of the count, which needs the full write-start-wait-read sequence to observe.

// File: rtl/cdt_pkg.sv
// Package: shared constants for the prescaled countdown timer.
// Assumes a byte-wide register port with a 2-bit address.
package cdt_pkg;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 8;
    // Control byte bit positions.
    localparam int BIT_RUN   = 0;
    localparam int BIT_LOAD  = 1;
    localparam int BIT_SEL   = 2;
    localparam int BIT_FLAG  = 3;
    // Address map.
    localparam logic [ADDR_W-1:0] ADR_CTRL      = 2'd0;
    localparam int                ADR_LANE_BASE = 1;
endpackage

// File: rtl/cdt_prescaler.sv
// Module: cdt_prescaler
// Makes a single-cycle tick enable every DIV_SLOW or DIV_FAST clocks,
// chosen by sel. It advances only while run is high, and restart puts
// the phase back to zero. Assumes DIV_SLOW >= DIV_FAST >= 2.
module cdt_prescaler #(
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic sel,
    output logic tick
);
    localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] limit;

    // Pick the terminal phase for the selected ratio.
    always_comb limit = sel ? LIM_FAST : LIM_SLOW;

    // Tick on the terminal phase while running and not restarting.
    always_comb tick = run && !restart && (phase >= limit);

    // Advance the phase counter, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (run)
            phase <= (phase >= limit) ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/cdt_count_core.sv
// Module: cdt_count_core
// Holds the down-counter. A load copies the reload value and wins over
// a tick. A tick decrements a non-zero count, and zero saturates.
// hit_zero pulses when a tick moves the count from one to zero.
module cdt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Flag the step from one to zero.
    always_comb hit_zero = tick && !load && (count == ONE);

    // Update the count: load first, then a saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= reload;
        else if (tick && (count != '0))
            count <= count - ONE;
    end
endmodule

// File: rtl/cdt_ctrl_regs.sv
// Module: cdt_ctrl_regs
// Decodes register writes. Keeps run, clock select, pending load,
// the timeout flag and the byte lanes of the reload value. Assumes
// CNT_W is a whole multiple of DATA_W.
module cdt_ctrl_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit_zero,
    output logic              run_q,
    output logic              sel_q,
    output logic              load_pend,
    output logic              flag_q,
    output logic              start,
    output logic [CNT_W-1:0]  reload
);
    localparam int LANES = CNT_W / DATA_W;

    logic ctrl_wr;
    logic [DATA_W-1:0] lane_q [LANES];

    // Decode a control write and a start from stopped.
    always_comb begin
        ctrl_wr = wr_en && (addr == ADR_CTRL);
        start   = ctrl_wr && wdata[BIT_RUN] && !run_q;
    end

    // Run bit follows each control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (ctrl_wr)
            run_q <= wdata[BIT_RUN];
    end

    // Clock select is taken only when not staying in the running state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if (ctrl_wr && !(run_q && wdata[BIT_RUN]))
            sel_q <= wdata[BIT_SEL];
    end

    // Load request lasts one cycle, which is when the counter loads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_pend <= 1'b0;
        else
            load_pend <= ctrl_wr && wdata[BIT_LOAD];
    end

    // Timeout flag: set at zero, cleared by write-one or by stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit_zero)
            flag_q <= 1'b1;
        else if (ctrl_wr && (wdata[BIT_FLAG] || !wdata[BIT_RUN]))
            flag_q <= 1'b0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Store one byte of the reload value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[i] <= '0;
            else if (wr_en && (addr == ADDR_W'(ADR_LANE_BASE + i)))
                lane_q[i] <= wdata;
        end
        assign reload[i*DATA_W +: DATA_W] = lane_q[i];
    end
endmodule

// File: rtl/cdtimer_top.sv
// Module: cdtimer_top
// Prescaled 16-bit countdown timer with a byte register port.
// Assumes one system clock domain and a synchronous active-low reset.
// Reads are combinational from addr.
module cdtimer_top
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  timeout
);
    localparam int LANES = CNT_W / DATA_W;

    logic             run_q;
    logic             sel_q;
    logic             load_pend;
    logic             flag_q;
    logic             start;
    logic             tick;
    logic             hit_zero;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;

    cdt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .hit_zero(hit_zero), .run_q(run_q),
        .sel_q(sel_q), .load_pend(load_pend), .flag_q(flag_q),
        .start(start), .reload(reload)
    );

    cdt_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(start),
        .sel(sel_q), .tick(tick)
    );

    cdt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load_pend), .tick(tick),
        .reload(reload), .count(cnt), .hit_zero(hit_zero)
    );

    // Drive the flag output.
    assign timeout = flag_q;

    // Read mux: control byte or one lane of the live count.
    always_comb begin
        rdata = '0;
        if (addr == ADR_CTRL) begin
            rdata[BIT_RUN]  = run_q;
            rdata[BIT_LOAD] = load_pend;
            rdata[BIT_SEL]  = sel_q;
            rdata[BIT_FLAG] = flag_q;
        end
        for (int i = 0; i < LANES; i++) begin
            if (addr == ADDR_W'(ADR_LANE_BASE + i))
                rdata = cnt[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/cdtimer_chk.sv
// Module: cdtimer_chk
// Cycle-level property checks for cdtimer_top, attached by bind.
module cdtimer_chk
    import cdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout,
    input  logic              run,
    input  logic              sel,
    input  logic              load_pend,
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  reload
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == ADR_CTRL);

    // R6
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load_pend) |=> (count == '0));

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_pend) |=> (count == $past(count)));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_pend) |=>
        (count == $past(count) || count == $past(count) - CNT_W'(1)));

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pend |=> (count == $past(reload)));

    // R3
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend && !(ctrl_wr && wdata[BIT_LOAD])) |=> !load_pend);

    // R9
    sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_wr && wdata[BIT_RUN]) |=> (sel == $past(sel)));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[BIT_RUN] && !tick) |=> !timeout);

    // R5
    flag_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (count == '0));
endmodule

bind cdtimer_top cdtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .timeout(timeout), .run(run_q), .sel(sel_q), .load_pend(load_pend),
    .tick(tick), .count(cnt), .reload(reload)
);

// File: tb/sim_cdtimer_top.sv
// Bench for cdtimer_top: directed corner cases plus seeded random runs.
module sim_cdtimer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       timeout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    cdtimer_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .timeout(timeout)
    );

    always #5 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One register write, entered and left at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    // Combinational read at the current falling edge.
    task automatic rd(input logic [1:0] a, output int d);
        addr = a;
        #1;
        d = rdata;
        addr = 2'd0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count value read as two bytes.
    task automatic rd_cnt(output int v);
        int lo;
        int hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = (hi << 8) | lo;
    endtask

    // Expected count n edges after a load-and-start write.
    function automatic int exp_count(int v, int n, int div);
        int s = n / div;
        return (s >= v) ? 0 : v - s;
    endfunction

    function automatic int exp_flag(int v, int n, int div);
        return (v != 0 && (n / div) >= v) ? 1 : 0;
    endfunction

    initial begin
        int d;
        int c;
        void'($urandom(32'd2024));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd_cnt(c);   chk("R1 count", c, 0);
        chk("R1 timeout", timeout, 0);

        // R10 reload bytes, R3 load only
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        wr(2'd0, 8'h02);
        rd(2'd0, d); chk("R3 load bit set", (d >> 1) & 1, 1);
        step(1);
        rd(2'd0, d); chk("R3 load bit self-clears", (d >> 1) & 1, 0);
        rd(2'd1, d); chk("R10 low byte", d, 8'h34);
        rd(2'd2, d); chk("R10 high byte", d, 8'h12);

        // R2 stopped counter holds
        step(40);
        rd_cnt(c); chk("R2 hold when stopped", c, 16'h1234);

        // R4 fast ratio, R11 prescaler restart on start
        wr(2'd0, 8'h05);
        step(10);
        rd_cnt(c); chk("R4 divide by 2", c, 16'h1234 - 5);

        // R9 select ignored while running
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R9 select kept", (d >> 2) & 1, 1);

        // R11 load+start together, R4 divide by 16, R5 flag
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h03);
        step(15);
        rd_cnt(c); chk("R11 before first tick", c, 3);
        step(1);
        rd_cnt(c); chk("R11 first tick at 16", c, 2);
        step(31);
        rd_cnt(c); chk("R4 divide by 16", c, 1);
        chk("R5 flag not yet", timeout, 0);
        step(1);
        rd_cnt(c); chk("R5 count zero", c, 0);
        chk("R5 timeout port", timeout, 1);
        rd(2'd0, d); chk("R5 flag bit", (d >> 3) & 1, 1);

        // R6 no wrap
        step(40);
        rd_cnt(c); chk("R6 stays zero", c, 0);
        chk("R6 flag stays", timeout, 1);

        // R7 write of zero keeps, write of one clears
        wr(2'd0, 8'h01);
        chk("R7 zero write keeps flag", timeout, 1);
        wr(2'd0, 8'h09);
        chk("R7 write-one clears", timeout, 0);
        rd(2'd0, d); chk("R7 still running", d & 1, 1);

        // R8 stop clears the flag
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h07);
        step(2);
        chk("R8 flag set again", timeout, 1);
        wr(2'd0, 8'h00);
        chk("R8 stop clears", timeout, 0);
        rd_cnt(c); chk("R8 count zero", c, 0);

        // Random runs: R2 R4 R5 R6 R10 R11
        for (int it = 0; it < 40; it++) begin
            int v = $urandom_range(0, 300);
            int s = $urandom_range(0, 1);
            int div = s ? 2 : 16;
            int n = $urandom_range(1, v * div + 40);
            if (n > 1500) n = 1500;
            wr(2'd0, 8'h00);
            wr(2'd1, 8'(v));
            wr(2'd2, 8'(v >> 8));
            wr(2'd0, 8'(8'h03 | (s << 2)));
            step(n);
            rd_cnt(c);
            chk("R2 R4 R11 random count", c, exp_count(v, n, div));
            chk("R5 R6 random flag", timeout, exp_flag(v, n, div));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule